// File: doc/BRIEF.md
# Tug-of-War Position Controller

The block runs a two-player tug-of-war game. Each player has a pulse input that pulls a marker one step toward that player's side. Seven output lines show the marker's position, and exactly one line is high at any time. When the marker reaches either outermost position, that player has won and the marker stays where it is until reset. Each pulse input must be high for exactly one clock cycle per press. Debouncing and pulse shaping are done upstream of this block.

The game state lives in an up/down counter with an enable input, a direction input and a synchronous clear. The counter holds the signed offset of the marker from the centre, so clearing it puts the game in the middle. A binary-to-one-hot decoder drives the lines from the counter value. A small gate network builds the counter's enable and direction from the two pulses and from the decoder's two end outputs.

Top module: `rope_game`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is cleared, and from the following cycle `led_o` equals 7'b0001000, which is the centre position S3.
- R2: Once reset has been applied, exactly one bit of `led_o` is high in every cycle. Bit i high means the marker is at position Si.
- R3: A cycle with `pull_l` high, `pull_r` low and the marker at neither S0 nor S6 moves the marker one position toward S0 (the lit bit index drops by one) at the next edge.
- R4: A cycle with `pull_r` high, `pull_l` low and the marker at neither S0 nor S6 moves the marker one position toward S6 (the lit bit index rises by one) at the next edge.
- R5: A cycle with both pulses high, or with both low, leaves `led_o` unchanged.
- R6: Once the marker is at S0 or S6, no pulse pattern changes `led_o` until reset.
- R7: Reset takes priority over any pulse in the same cycle. It also returns the marker to S3 from either end position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; clears the position counter |
| pull_l | input | 1 | One-cycle pulse pulling toward S0 |
| pull_r | input | 1 | One-cycle pulse pulling toward S6 |
| led_o | output | 7 | One-hot marker position, bit i = Si |

## Verification
From every one of the seven positions, the bench applies each of the four pulse combinations.

- The single-pulse combinations show whether the direction is correct.
- The both-high combination shows whether the enable uses the exclusive-OR of the pulses rather than the OR.
- Running the same patterns at S0 and S6 shows whether the winning positions freeze.

A long pseudo-random pulse stream with periodic resets then tests move sequences and resets that arrive together with a pulse against an arithmetic position model.

// File: rtl/rope_pkg.sv
package rope_pkg;
   // Pull direction as seen by the position counter
   typedef enum logic {
      STEP_UP   = 1'b0,
      STEP_DOWN = 1'b1
   } step_dir_e;
endpackage

// File: rtl/updown_cnt.sv
module updown_cnt
   import rope_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         en,
   input  step_dir_e    dir,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_w
      $error("updown_cnt: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (clr)
         q <= '0;
      else if (en)
         q <= (dir == STEP_DOWN) ? q - ONE : q + ONE;
   end

   // R1
   clear_zero_chk: assert property (@(posedge clk) clr |=> q == '0);

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (clr)
      !en |=> q == $past(q));
endmodule

// File: rtl/sel_decoder.sv
module sel_decoder #(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0]      sel,
   output logic [2**SEL_W-1:0]   hot
);
   localparam int N_OUT = 2**SEL_W;

   if (SEL_W < 1) begin : g_bad_sel
      $error("sel_decoder: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      assign hot[i] = (sel == SEL_W'(i));
   end

   // R2
   always_comb begin
      one_line_chk: assert (!$isunknown(sel) -> $countones(hot) == 1);
   end
endmodule

// File: rtl/pull_ctrl.sv
module pull_ctrl
   import rope_pkg::*;
(
   input  logic      pull_l,
   input  logic      pull_r,
   input  logic      at_lo,
   input  logic      at_hi,
   output logic      cnt_en,
   output step_dir_e cnt_dir
);
   // Count only on a lone pulse, and never once a side has won
   assign cnt_en  = (pull_l ^ pull_r) & ~(at_lo | at_hi);
   // The left pulse alone picks the direction; both-high never enables
   assign cnt_dir = pull_l ? STEP_DOWN : STEP_UP;
endmodule

// File: rtl/rope_game.sv
module rope_game
   import rope_pkg::*;
#(
   parameter int NUM_POS = 7,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pull_l,
   input  logic               pull_r,
   output logic [NUM_POS-1:0] led_o
);
   localparam int SEL_W  = $clog2(NUM_POS);
   localparam int N_DEC  = 2**SEL_W;
   localparam int CENTRE = (NUM_POS - 1) / 2;
   localparam logic [CNT_W-1:0] CENTRE_C = CNT_W'(CENTRE);
   localparam logic [NUM_POS-1:0] MID_HOT = NUM_POS'(1) << CENTRE;

   if (NUM_POS % 2 == 0 || NUM_POS < 3) begin : g_bad_pos
      $error("rope_game: NUM_POS must be odd and at least 3");
   end
   if (CNT_W < SEL_W || (2**(CNT_W-1)) <= CENTRE) begin : g_bad_cnt
      $error("rope_game: CNT_W too small for the position range");
   end

   logic [CNT_W-1:0] offset;
   logic [CNT_W-1:0] idx_full;
   logic [N_DEC-1:0] dec_hot;
   logic             cnt_en;
   step_dir_e        cnt_dir;

   updown_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .clr (rst),
      .en  (cnt_en),
      .dir (cnt_dir),
      .q   (offset)
   );

   // The counter holds the signed offset from centre, so clear means S3
   assign idx_full = offset + CENTRE_C;

   sel_decoder #(.SEL_W(SEL_W)) u_dec (
      .sel (idx_full[SEL_W-1:0]),
      .hot (dec_hot)
   );

   pull_ctrl u_ctrl (
      .pull_l  (pull_l),
      .pull_r  (pull_r),
      .at_lo   (dec_hot[0]),
      .at_hi   (dec_hot[NUM_POS-1]),
      .cnt_en  (cnt_en),
      .cnt_dir (cnt_dir)
   );

   assign led_o = dec_hot[NUM_POS-1:0];

   // R2
   pos_range_chk: assert property (@(posedge clk) disable iff (rst)
      idx_full < CNT_W'(NUM_POS));

   // R2
   spare_dark_chk: assert property (@(posedge clk) disable iff (rst)
      dec_hot[N_DEC-1:NUM_POS] == '0);

   // R1
   reset_centre_chk: assert property (@(posedge clk)
      rst |=> led_o == MID_HOT);

   // R2
   single_led_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(led_o) == 1);

   // R3
   step_left_chk: assert property (@(posedge clk) disable iff (rst)
      (pull_l && !pull_r && !led_o[0] && !led_o[NUM_POS-1])
      |=> led_o == ($past(led_o) >> 1));

   // R4
   step_right_chk: assert property (@(posedge clk) disable iff (rst)
      (pull_r && !pull_l && !led_o[0] && !led_o[NUM_POS-1])
      |=> led_o == ($past(led_o) << 1));

   // R5
   no_move_chk: assert property (@(posedge clk) disable iff (rst)
      (pull_l == pull_r) |=> $stable(led_o));

   // R6
   end_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (led_o[0] || led_o[NUM_POS-1]) |=> $stable(led_o));
endmodule

// File: tb/rope_game_tb.sv
module rope_game_tb;
   localparam int NP = 7;
   localparam int MID = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pull_l = 1'b0;
   logic          pull_r = 1'b0;
   logic [NP-1:0] led_o;

   int n_chk  = 0;
   int n_fail = 0;
   int pos    = MID;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rope_game u_dut (
      .clk    (clk),
      .rst    (rst),
      .pull_l (pull_l),
      .pull_r (pull_r),
      .led_o  (led_o)
   );

   task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp,
                        input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: led_o=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic r, input logic rs);
      string req;
      @(negedge clk);
      pull_l = l;
      pull_r = r;
      rst    = rs;
      if (rs)                       req = "R7";
      else if (pos == 0 || pos == NP-1) req = "R6";
      else if (l == r)              req = "R5";
      else if (l)                   req = "R3";
      else                          req = "R4";
      @(posedge clk);
      #1;
      if (rs)
         pos = MID;
      else if ((l ^ r) && pos != 0 && pos != NP-1)
         pos = r ? pos + 1 : pos - 1;
      check(led_o, NP'(1) << pos, req);
      n_chk++;
      if ($countones(led_o) != 1) begin
         n_fail++;
         $display("FAIL R2: led_o=%b expected exactly one bit set", led_o);
      end
   endtask

   initial begin
      logic [15:0] lf;
      // R1: reset state
      @(posedge clk);
      #1;
      pos = MID;
      check(led_o, 7'b0001000, "R1");
      step(1'b0, 1'b0, 1'b1);

      // R3 R4 R5 R6: every start position against every pulse pattern
      for (int s = 0; s < NP; s++) begin
         for (int c = 0; c < 4; c++) begin
            step(1'b0, 1'b0, 1'b1);
            for (int k = 0; k < (s > MID ? s - MID : MID - s); k++)
               step(s < MID, s > MID, 1'b0);
            step(c[1], c[0], 1'b0);
            step(1'b0, 1'b0, 1'b0);
         end
      end

      // R7: reset with pulses, from both ends
      step(1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);

      // Pseudo-random pulse stream with periodic resets
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0], lf[5], (i % 157) == 156);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule